// File: doc/BRIEF.md
# External Memory Wait-State Controller

This block sits between an internal processor bus and three external memory regions: a read-only region, a RAM region and an extended-memory region. Each region has its own active-low chip select. A 16-bit control register holds a wait count of 0 to 7 and a data-width choice (8 or 16 bits) for each region. Two merge bits let the RAM select, the ROM select, or both also assert during extended-memory accesses.

The bus raises a request with an address, a direction, write data and an access size. The block decodes the region from fixed address windows, which are parameters. It drives the select and the read or write strobe, and holds them for one cycle plus the programmed wait count. A 16-bit access to an 8-bit region becomes two byte cycles, low byte first. A one-cycle acknowledge then signals completion, and the read data is valid on that cycle. The configuration is sampled when an access is accepted, so a register write made during an access only affects later accesses.

Top module: `ext_mem_waitctl`

## Requirements
- R1: After reset the control register reads 0x0000, all three selects and both strobes are high, and the acknowledge is low.
- R2: A register write stores bits 13:0 and forces bits 15:14 to zero on read-back. The field layout is: bit 13 RAM merge, bit 12 ROM merge, bit 11 extended width, bits 10:8 extended wait, bit 7 ROM width, bits 6:4 ROM wait, bit 3 RAM width, bits 2:0 RAM wait. A width bit of 1 means 8 bits.
- R3: An address selects at most one region by its window, checked in the priority ROM, RAM, extended. Without merging, only that region's select goes low.
- R4: Each byte or word cycle holds the select low for exactly wait+1 clocks, so a zero wait count gives exactly one clock.
- R5: The acknowledge is high for exactly one clock, on the clock after the last cycle of the access. All selects are high during that clock, and the read data is valid in it.
- R6: A 16-bit access (busWide=1) to an 8-bit region runs two back-to-back byte cycles, each with the full wait count. The first is at the address and carries byte 7:0, the second is at the address+1 and carries byte 15:8. Both use memory lane 7:0, and the read result is {second byte, first byte}.
- R7: An access to a 16-bit region runs a single cycle with the full 16-bit word. A byte access (busWide=0) to an 8-bit region runs a single cycle and returns {8'h00, lane 7:0}.
- R8: With RAM merge set, the RAM select is low during every clock in which an extended-memory access holds the extended select low.
- R9: With ROM merge set, the ROM select is low during every clock in which an extended-memory access holds the extended select low.
- R10: A register write made while an access is in progress leaves that access's timing unchanged. It applies from the next accepted access.
- R11: An address outside every window asserts no select and no strobe. It is acknowledged on the second clock after acceptance, and a read returns 0x0000.
- R12: The write strobe is low exactly while the select is low on a write, and the read strobe is low exactly while the select is low on a read. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Control register write enable |
| regWdata | input | 16 | Control register write data |
| regRdata | output | 16 | Control register read-back |
| busReq | input | 1 | Access request; accepted when idle and acknowledge is low |
| busWe | input | 1 | 1 = write access, 0 = read |
| busWide | input | 1 | 1 = 16-bit access, 0 = byte access |
| busAddr | input | ADDR_W | Access address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid while busAck is high |
| busAck | output | 1 | One-cycle completion pulse |
| memAddr | output | ADDR_W | External address |
| memWdata | output | 16 | External write data |
| memRdata | input | 16 | External read data |
| memWeN | output | 1 | Active-low write strobe |
| memOeN | output | 1 | Active-low read strobe |
| selRomN | output | 1 | ROM region select, active low |
| selRamN | output | 1 | RAM region select, active low |
| selExtN | output | 1 | Extended region select, active low |

## Verification
The bench builds the block with an 8-bit address and four 64-byte windows: ROM at 0x00, RAM at 0x40, extended memory at 0x80, and an unmapped window at 0xC0. With this small address space, every wait count, both widths, both directions and all four merge settings are swept for each region in a few hundred accesses. The memory model returns data computed from the address, so the bench can check byte ordering and the address+1 step of a split access arithmetically. Separate runs cover byte accesses, the unmapped window, the register read-back and a register write made during an access.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

  localparam int CFG_W   = 16;
  localparam int WAIT_W  = 3;
  localparam int DATA_W  = 16;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_ROM  = 2'd1,
    RG_RAM  = 2'd2,
    RG_EXT  = 2'd3
  } region_e;

  // control -> datapath strobes
  typedef struct packed {
    logic accept;   // capture request and config snapshot
    logic lowDone;  // first byte cycle of a split access ends
    logic finish;   // last cycle of the access ends
    logic active;   // an access cycle is running
    logic beat;     // second byte cycle of a split access
  } strobe_t;

endpackage

// File: rtl/ewc_ctrl.sv
module ewc_ctrl
  import ewc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic [WAIT_W-1:0] startWait,
  input  logic              startSplit,
  output strobe_t           strb,
  output logic              busAck
);

  logic              busyQ;
  logic              splitQ;
  logic              beatQ;
  logic              ackQ;
  logic [WAIT_W-1:0] cntQ;
  logic [WAIT_W-1:0] reloadQ;

  logic accept;
  logic beatEnd;
  logic lowDone;
  logic finish;

  assign accept  = ~busyQ & ~ackQ & busReq;
  assign beatEnd = busyQ & (cntQ == '0);
  assign lowDone = beatEnd & splitQ & ~beatQ;
  assign finish  = beatEnd & ~lowDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      splitQ  <= 1'b0;
      beatQ   <= 1'b0;
      ackQ    <= 1'b0;
      cntQ    <= '0;
      reloadQ <= '0;
    end else begin
      ackQ <= finish;
      if (accept) begin
        busyQ   <= 1'b1;
        splitQ  <= startSplit;
        beatQ   <= 1'b0;
        cntQ    <= startWait;
        reloadQ <= startWait;
      end else if (lowDone) begin
        beatQ <= 1'b1;
        cntQ  <= reloadQ;
      end else if (finish) begin
        busyQ <= 1'b0;
        beatQ <= 1'b0;
      end else if (busyQ) begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  always_comb begin
    strb.accept  = accept;
    strb.lowDone = lowDone;
    strb.finish  = finish;
    strb.active  = busyQ;
    strb.beat    = beatQ;
  end

  assign busAck = ackQ;

endmodule

// File: rtl/ewc_datapath.sv
module ewc_datapath
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h0000,
  parameter int ROM_LOG2 = 14,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h4000,
  parameter int RAM_LOG2 = 14,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h8000,
  parameter int EXT_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [CFG_W-1:0]  regWdata,
  output logic [CFG_W-1:0]  regRdata,
  input  logic              busWe,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  strobe_t           strb,
  output logic [WAIT_W-1:0] startWait,
  output logic              startSplit,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWeN,
  output logic              memOeN,
  output logic              selRomN,
  output logic              selRamN,
  output logic              selExtN
);

  localparam int RSV_W = 2;

  logic [CFG_W-1:0]  cfgQ;
  region_e           reqRegion;
  logic              reqNarrow;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic [BYTE_W-1:0] lowByteQ;
  logic              weQ;
  logic              wideQ;
  logic              narrowQ;
  logic              ramMergeQ;
  logic              romMergeQ;
  region_e           regionQ;

  logic mapped;
  logic act;

  // configuration register, reserved bits held at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (regWe) cfgQ <= {{RSV_W{1'b0}}, regWdata[CFG_W-RSV_W-1:0]};
  end
  assign regRdata = cfgQ;

  // window decode, ROM first, then RAM, then extended
  always_comb begin
    reqRegion = RG_NONE;
    if (busAddr[ADDR_W-1:ROM_LOG2] == ROM_BASE[ADDR_W-1:ROM_LOG2])      reqRegion = RG_ROM;
    else if (busAddr[ADDR_W-1:RAM_LOG2] == RAM_BASE[ADDR_W-1:RAM_LOG2]) reqRegion = RG_RAM;
    else if (busAddr[ADDR_W-1:EXT_LOG2] == EXT_BASE[ADDR_W-1:EXT_LOG2]) reqRegion = RG_EXT;
  end

  always_comb begin
    unique case (reqRegion)
      RG_ROM:  begin startWait = cfgQ[6:4];  reqNarrow = cfgQ[7];  end
      RG_RAM:  begin startWait = cfgQ[2:0];  reqNarrow = cfgQ[3];  end
      RG_EXT:  begin startWait = cfgQ[10:8]; reqNarrow = cfgQ[11]; end
      default: begin startWait = '0;         reqNarrow = 1'b0;     end
    endcase
  end
  assign startSplit = reqNarrow & busWide;

  // request and configuration snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      weQ       <= 1'b0;
      wideQ     <= 1'b0;
      narrowQ   <= 1'b0;
      ramMergeQ <= 1'b0;
      romMergeQ <= 1'b0;
      regionQ   <= RG_NONE;
    end else if (strb.accept) begin
      addrQ     <= busAddr;
      wdataQ    <= busWdata;
      weQ       <= busWe;
      wideQ     <= busWide;
      narrowQ   <= reqNarrow;
      ramMergeQ <= cfgQ[13];
      romMergeQ <= cfgQ[12];
      regionQ   <= reqRegion;
    end
  end

  assign mapped = (regionQ != RG_NONE);
  assign act    = strb.active & mapped;

  assign memAddr  = addrQ + ADDR_W'(strb.beat);
  assign memWdata = narrowQ ? {{BYTE_W{1'b0}}, (strb.beat ? wdataQ[DATA_W-1:BYTE_W] : wdataQ[BYTE_W-1:0])}
                            : wdataQ;

  assign memWeN  = ~(act & weQ);
  assign memOeN  = ~(act & ~weQ);
  assign selRomN = ~(act & ((regionQ == RG_ROM) | (romMergeQ & (regionQ == RG_EXT))));
  assign selRamN = ~(act & ((regionQ == RG_RAM) | (ramMergeQ & (regionQ == RG_EXT))));
  assign selExtN = ~(act & (regionQ == RG_EXT));

  // read data assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByteQ <= '0;
      rdataQ   <= '0;
    end else begin
      if (strb.lowDone) lowByteQ <= memRdata[BYTE_W-1:0];
      if (strb.finish && !weQ) begin
        if (!mapped)     rdataQ <= '0;
        else if (!narrowQ) rdataQ <= memRdata;
        else if (wideQ)  rdataQ <= {memRdata[BYTE_W-1:0], lowByteQ};
        else             rdataQ <= {{BYTE_W{1'b0}}, memRdata[BYTE_W-1:0]};
      end
    end
  end
  assign busRdata = rdataQ;

endmodule

// File: rtl/ext_mem_waitctl.sv
module ext_mem_waitctl
  import ewc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'h0000,
  parameter int ROM_LOG2 = 14,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h4000,
  parameter int RAM_LOG2 = 14,
  parameter logic [ADDR_W-1:0] EXT_BASE = 16'h8000,
  parameter int EXT_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              busReq,
  input  logic              busWe,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              busAck,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic              memWeN,
  output logic              memOeN,
  output logic              selRomN,
  output logic              selRamN,
  output logic              selExtN
);

  strobe_t           strb;
  logic [WAIT_W-1:0] startWait;
  logic              startSplit;

  ewc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .startWait  (startWait),
    .startSplit (startSplit),
    .strb       (strb),
    .busAck     (busAck)
  );

  ewc_datapath #(
    .ADDR_W   (ADDR_W),
    .ROM_BASE (ROM_BASE), .ROM_LOG2 (ROM_LOG2),
    .RAM_BASE (RAM_BASE), .RAM_LOG2 (RAM_LOG2),
    .EXT_BASE (EXT_BASE), .EXT_LOG2 (EXT_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .busWe      (busWe),
    .busWide    (busWide),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .strb       (strb),
    .startWait  (startWait),
    .startSplit (startSplit),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .memWeN     (memWeN),
    .memOeN     (memOeN),
    .selRomN    (selRomN),
    .selRamN    (selRamN),
    .selExtN    (selExtN)
  );

endmodule

// File: rtl/ewc_checker.sv
module ewc_checker (
  input logic clk,
  input logic rstN,
  input logic busAck,
  input logic memWeN,
  input logic memOeN,
  input logic selRomN,
  input logic selRamN,
  input logic selExtN
);

  // R3: ROM and RAM selects only meet during a merged extended access
  p_rom_ram_merge_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!selRomN && !selRamN) |-> !selExtN);

  // R5: acknowledge lasts a single clock
  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R5: selects released while acknowledging
  p_ack_idle_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> (selRomN && selRamN && selExtN));

  // R12: strobes never together, and only with a select
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  p_strobe_needs_sel_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || !memOeN) |-> !(selRomN && selRamN && selExtN));

endmodule

bind ext_mem_waitctl ewc_checker u_ewc_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busAck  (busAck),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .selRomN (selRomN),
  .selRamN (selRamN),
  .selExtN (selExtN)
);

// File: tb/ext_mem_waitctl_bench.sv
`timescale 1ns/1ps
module ext_mem_waitctl_bench;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [15:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic          busReq = 1'b0;
  logic          busWe = 1'b0;
  logic          busWide = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [15:0]   busWdata = '0;
  logic [15:0]   busRdata;
  logic          busAck;
  logic [AW-1:0] memAddr;
  logic [15:0]   memWdata;
  logic [15:0]   memRdata;
  logic          memWeN, memOeN, selRomN, selRamN, selExtN;

  int nChecks = 0;
  int nFails  = 0;

  // access observations
  int            cRom, cRam, cExt, cWe, cOe, lat;
  logic [AW-1:0] fAddr, lAddr;
  logic [15:0]   fData, lData;

  always #5 clk = ~clk;

  assign memRdata = {~memAddr, memAddr};

  ext_mem_waitctl #(
    .ADDR_W (AW),
    .ROM_BASE (8'h00), .ROM_LOG2 (6),
    .RAM_BASE (8'h40), .RAM_LOG2 (6),
    .EXT_BASE (8'h80), .EXT_LOG2 (6)
  ) u_ext_mem_waitctl (
    .clk (clk), .rstN (rstN),
    .regWe (regWe), .regWdata (regWdata), .regRdata (regRdata),
    .busReq (busReq), .busWe (busWe), .busWide (busWide),
    .busAddr (busAddr), .busWdata (busWdata), .busRdata (busRdata), .busAck (busAck),
    .memAddr (memAddr), .memWdata (memWdata), .memRdata (memRdata),
    .memWeN (memWeN), .memOeN (memOeN),
    .selRomN (selRomN), .selRamN (selRamN), .selExtN (selExtN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] v);
    @(negedge clk);
    regWe = 1'b1; regWdata = v;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // runs one access; optionally writes the register during it
  task automatic runAccess(input logic [AW-1:0] a, input bit we, input bit wide,
                           input logic [15:0] wd, input bit midWr, input logic [15:0] midVal);
    cRom = 0; cRam = 0; cExt = 0; cWe = 0; cOe = 0; lat = 0;
    fAddr = '0; lAddr = '0; fData = '0; lData = '0;
    @(negedge clk);
    busReq = 1'b1; busAddr = a; busWe = we; busWide = wide; busWdata = wd;
    @(negedge clk);
    busReq = 1'b0;
    if (midWr) begin regWe = 1'b1; regWdata = midVal; end
    for (int k = 1; k <= 40; k++) begin
      if (k == 2) regWe = 1'b0;
      if (busAck) begin lat = k; break; end
      if (!selRomN) cRom++;
      if (!selRamN) cRam++;
      if (!selExtN) cExt++;
      if (!memWeN) begin
        if (cWe == 0) begin fAddr = memAddr; fData = memWdata; end
        lAddr = memAddr; lData = memWdata;
        cWe++;
      end
      if (!memOeN) cOe++;
      @(negedge clk);
    end
    regWe = 1'b0;
    @(negedge clk);
    check(!busAck, "R5 ack single clock", int'(busAck), 0);
  endtask

  function automatic logic [15:0] cfgFor(input int rg, input int w, input int nar, input int mg);
    logic [3:0] f, o;
    f = {nar[0], w[2:0]};
    o = {~nar[0], 3'(7 - w)};
    return {2'b00, mg[0], mg[1], (rg == 2 ? f : o), (rg == 0 ? f : o), (rg == 1 ? f : o)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] bases [3];
    bases[0] = 8'h00; bases[1] = 8'h40; bases[2] = 8'h80;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(regRdata == 16'h0000, "R1 reg reset", regRdata, 0);
    check({selRomN, selRamN, selExtN, memWeN, memOeN} == 5'b11111, "R1 idle outputs",
          {selRomN, selRamN, selExtN, memWeN, memOeN}, 5'b11111);
    check(!busAck, "R1 ack low", busAck, 0);
    rstN = 1'b1;

    // R2 read-back
    writeReg(16'hFFFF);
    check(regRdata == 16'h3FFF, "R2 reserved bits zero", regRdata, 16'h3FFF);
    writeReg(16'h1234);
    check(regRdata == 16'h1234, "R2 readback", regRdata, 16'h1234);

    // main sweep: R3 R4 R5 R6 R7 R8 R9 R12
    for (int rg = 0; rg < 3; rg++)
      for (int w = 0; w < 8; w++)
        for (int nar = 0; nar < 2; nar++)
          for (int we = 0; we < 2; we++)
            for (int mg = 0; mg < 4; mg++) begin
              logic [AW-1:0] a;
              logic [15:0]   wd;
              int n, eRom, eRam, eExt;
              a  = bases[rg] + AW'(w * 4 + 1);
              wd = 16'hA55A ^ {a, 8'(w * 17 + nar + mg)};
              writeReg(cfgFor(rg, w, nar, mg));
              runAccess(a, we[0], 1'b1, wd, 1'b0, 16'h0);
              n = (nar + 1) * (w + 1);
              eRom = (rg == 0 || (rg == 2 && mg[1])) ? n : 0;
              eRam = (rg == 1 || (rg == 2 && mg[0])) ? n : 0;
              eExt = (rg == 2) ? n : 0;
              check(cRom == eRom, "R3 R4 R9 rom select clocks", cRom, eRom);
              check(cRam == eRam, "R3 R4 R8 ram select clocks", cRam, eRam);
              check(cExt == eExt, "R3 R4 ext select clocks", cExt, eExt);
              check(lat == n + 1, "R5 ack timing", lat, n + 1);
              if (we) begin
                check(cWe == n && cOe == 0, "R12 write strobe", cWe, n);
                check(fAddr == a, "R6 R7 first address", fAddr, a);
                check(lAddr == (nar ? a + 8'd1 : a), "R6 second address", lAddr, nar ? a + 8'd1 : a);
                check(fData == (nar ? {8'h00, wd[7:0]} : wd), "R6 R7 first write data",
                      fData, nar ? {8'h00, wd[7:0]} : wd);
                check(lData == (nar ? {8'h00, wd[15:8]} : wd), "R6 R7 last write data",
                      lData, nar ? {8'h00, wd[15:8]} : wd);
              end else begin
                check(cOe == n && cWe == 0, "R12 read strobe", cOe, n);
                check(busRdata == (nar ? {a + 8'd1, a} : {~a, a}), "R6 R7 read data",
                      busRdata, nar ? {a + 8'd1, a} : {~a, a});
              end
            end

    // R7 byte accesses
    writeReg(16'h0083);                 // ROM 8-bit wait0, RAM 16-bit wait3
    runAccess(8'h21, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
    check(cRom == 1 && lat == 2, "R7 byte on 8-bit single cycle", cRom, 1);
    check(busRdata == 16'h0021, "R7 byte read zero-extended", busRdata, 16'h0021);
    runAccess(8'h52, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0);
    check(cRam == 4 && lat == 5, "R7 byte on 16-bit region", cRam, 4);
    check(busRdata == 16'hAD52, "R7 full word read", busRdata, 16'hAD52);

    // R11 unmapped window
    writeReg(16'h3777);
    runAccess(8'hC5, 1'b0, 1'b1, 16'h0, 1'b0, 16'h0);
    check(cRom + cRam + cExt == 0, "R11 no select", cRom + cRam + cExt, 0);
    check(cWe + cOe == 0, "R11 no strobe", cWe + cOe, 0);
    check(lat == 2, "R11 ack timing", lat, 2);
    check(busRdata == 16'h0000, "R11 read zero", busRdata, 0);

    // R10 write during access
    writeReg(16'h0020);                 // ROM wait 2
    runAccess(8'h05, 1'b0, 1'b1, 16'h0, 1'b1, 16'h0050);
    check(cRom == 3, "R10 running access keeps timing", cRom, 3);
    check(regRdata == 16'h0050, "R10 register updated", regRdata, 16'h0050);
    runAccess(8'h05, 1'b0, 1'b1, 16'h0, 1'b0, 16'h0);
    check(cRom == 6, "R10 next access uses new timing", cRom, 6);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule